// File: doc/BRIEF.md
# SECDED-Protected SRAM Wrapper with Read Scrubbing

This block wraps a synchronous 64-bit-wide storage array. It keeps an 8-bit single-error-correct, double-error-detect check code next to every stored word. Requesters issue 32-bit or 64-bit reads and writes over a valid/ready handshake. Protection is active from reset and needs no setup.

Read data always returns corrected. A 64-bit write encodes the word and stores it directly. A 32-bit write reads the whole word, repairs any single flipped bit, merges in the new lane, re-encodes and stores the result. When the scrub control is on, plain reads also store the repaired word, which removes transient faults from the array. With scrub off, a read never changes the array.

Two single-error notification pulses exist, one for the write path and one for the scrub path, each with its own enable. An uncorrectable error is always reported as an error response on the access. Sticky flags record the word address of the latest correctable error and the latest uncorrectable error.

Top module: `ecc_sram_wrap`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, rsp_err, both notification pulses, sbe_flag and dbe_flag are 0.
- R2: A 64-bit write (req_write=1, req_wide=1) followed by a read of the same address returns the written word with rsp_err=0.
- R3: A 32-bit write (req_write=1, req_wide=0) replaces only one lane of the stored word. req_upper=1 selects bits [63:32] and req_upper=0 selects bits [31:0], each taken from the same lane of req_wdata. The other lane of the stored word is kept.
- R4: A read of a word holding one flipped bit returns the original data with rsp_err=0, whether scrub_en is 0 or 1.
- R5: With scrub_en=0, a read leaves the stored word unchanged, so a correctable fault is detected again on the next access.
- R6: With scrub_en=1, a read stores the corrected word, so a following read finds no error.
- R7: A 32-bit write repairs a flipped bit in the lane it does not replace and stores the repaired word. sbe_wr_pulse fires with that write's response only when wr_notify_en=1.
- R8: sbe_scrub_pulse fires with a read's response only when scrub_en=1, scrub_notify_en=1 and a single-bit error was corrected.
- R9: A double-bit error gives rsp_err=1 on the response regardless of every enable. No write-back happens, so the stored word stays uncorrectable.
- R10: sbe_flag and dbe_flag are sticky. They capture the word address of the latest single-bit and double-bit error in sbe_addr and dbe_addr. A one-cycle pulse on sbe_clr or dbe_clr clears the matching flag.
- R11: req_ready drops for exactly one cycle after a read with no write-back. It drops for exactly two cycles after an access that writes back (a 32-bit write, or a read with scrub_en=1 and no double error). It stays high after a 64-bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scrub_en | input | 1 | Write back corrected word on plain reads |
| wr_notify_en | input | 1 | Enable single-error pulse for write-path corrections |
| scrub_notify_en | input | 1 | Enable single-error pulse for scrub corrections |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Wrapper can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_upper | input | 1 | Lane select for 32-bit writes (1 = bits 63:32) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data, lane aligned |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 64 | Corrected read data (0 for writes) |
| rsp_err | output | 1 | Uncorrectable error on this access |
| sbe_wr_pulse | output | 1 | Single error corrected on the write path |
| sbe_scrub_pulse | output | 1 | Single error corrected by scrubbing |
| sbe_flag | output | 1 | Sticky single-error flag |
| sbe_addr | output | ADDR_W | Address of latest single error |
| dbe_flag | output | 1 | Sticky double-error flag |
| dbe_addr | output | ADDR_W | Address of latest double error |
| sbe_clr | input | 1 | Clear sbe_flag |
| dbe_clr | input | 1 | Clear dbe_flag |

## Verification
The bench flips bits in stored code words, then checks what the array holds afterwards by reading the word again and watching sbe_flag. This catches a wrapper that corrects only the returned data and never writes back. It also catches one that scrubs while the scrub control is off.

A 32-bit write into a word with a flipped bit in the other lane exposes a merge that takes uncorrected data or the wrong lane. Double-bit faults test two things. The error response must ignore the enables. The write-back must be suppressed, or a second read would come back clean instead of still failing.

Busy-cycle counts catch a wrapper that accepts a new request during its write-back.

// File: rtl/ecc_sram_wrap.sv
module ecc_sram_wrap #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scrub_en,
  input  logic              wr_notify_en,
  input  logic              scrub_notify_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic              req_upper,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              sbe_wr_pulse,
  output logic              sbe_scrub_pulse,
  output logic              sbe_flag,
  output logic [ADDR_W-1:0] sbe_addr,
  output logic              dbe_flag,
  output logic [ADDR_W-1:0] dbe_addr,
  input  logic              sbe_clr,
  input  logic              dbe_clr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = 72;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WB} st_t;

  function automatic logic [CW-1:0] ecc_enc(input logic [63:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[j];
        j++;
      end
    for (int k = 0; k < 7; k++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < CW; p++)
        if (p[k]) x = x ^ c[p];
      c[1 << k] = x;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [63:0] ecc_data(input logic [CW-1:0] c);
    logic [63:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p < CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[j] = c[p];
        j++;
      end
    return d;
  endfunction

  logic [CW-1:0]     mem [DEPTH];
  st_t               state;
  logic [CW-1:0]     rd_q, wb_q;
  logic [ADDR_W-1:0] a_q;
  logic              wr_q, up_q;
  logic [31:0]       wd_q;

  logic              accept, wide_wr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic [CW-1:0]     mem_wd;

  logic [6:0]        syn;
  logic              ovp, sbe_c, dbe_c, do_wb;
  logic [CW-1:0]     fixed;
  logic [63:0]       fix_d, merged;

  assign req_ready = (state == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign wide_wr   = req_write && req_wide;

  assign mem_we = (accept && wide_wr) || (state == S_WB);
  assign mem_wa = (state == S_WB) ? a_q  : req_addr;
  assign mem_wd = (state == S_WB) ? wb_q : ecc_enc(req_wdata);

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
    if (accept) rd_q <= mem[req_addr];
  end

  always_comb begin
    syn = '0;
    for (int p = 1; p < CW; p++)
      if (rd_q[p]) syn = syn ^ p[6:0];
    ovp   = ^rd_q;
    sbe_c = ovp && (syn < 7'd72);
    dbe_c = (!ovp && syn != 7'd0) || (ovp && syn >= 7'd72);
    fixed = rd_q;
    if (sbe_c) fixed[syn] = ~rd_q[syn];
    fix_d  = ecc_data(fixed);
    merged = fix_d;
    if (wr_q) begin
      if (up_q) merged[63:32] = wd_q;
      else      merged[31:0]  = wd_q;
    end
  end

  assign do_wb = (wr_q || scrub_en) && !dbe_c;

  always_ff @(posedge clk) begin
    if (accept) begin
      wd_q <= req_upper ? req_wdata[63:32] : req_wdata[31:0];
      up_q <= req_upper;
    end
    if (state == S_RD) wb_q <= ecc_enc(merged);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= S_IDLE;
      a_q             <= '0;
      wr_q            <= 1'b0;
      rsp_valid       <= 1'b0;
      rsp_rdata       <= '0;
      rsp_err         <= 1'b0;
      sbe_wr_pulse    <= 1'b0;
      sbe_scrub_pulse <= 1'b0;
      sbe_flag        <= 1'b0;
      sbe_addr        <= '0;
      dbe_flag        <= 1'b0;
      dbe_addr        <= '0;
    end else begin
      rsp_valid       <= 1'b0;
      rsp_err         <= 1'b0;
      sbe_wr_pulse    <= 1'b0;
      sbe_scrub_pulse <= 1'b0;
      if (sbe_clr) sbe_flag <= 1'b0;
      if (dbe_clr) dbe_flag <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          a_q  <= req_addr;
          wr_q <= req_write;
          if (wide_wr) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= '0;
          end else begin
            state <= S_RD;
          end
        end
        S_RD: begin
          rsp_valid       <= 1'b1;
          rsp_rdata       <= wr_q ? 64'd0 : fix_d;
          rsp_err         <= dbe_c;
          sbe_wr_pulse    <= wr_q && sbe_c && wr_notify_en;
          sbe_scrub_pulse <= !wr_q && scrub_en && sbe_c && scrub_notify_en;
          if (sbe_c) begin
            sbe_flag <= 1'b1;
            sbe_addr <= a_q;
          end
          if (dbe_c) begin
            dbe_flag <= 1'b1;
            dbe_addr <= a_q;
          end
          state <= do_wb ? S_WB : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_busy_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wide_wr) |=> !req_ready);
  a_r11_free_after_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wide_wr) |=> req_ready && rsp_valid);
  a_r9_no_wb_on_dbe: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !mem_we);
  a_r9_err_only_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r7_wr_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sbe_wr_pulse |-> rsp_valid && $past(wr_notify_en));
  a_r8_scrub_pulse_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sbe_scrub_pulse |-> rsp_valid && $past(scrub_en && scrub_notify_en));
  a_r8_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sbe_wr_pulse, sbe_scrub_pulse}));
  a_r10_dbe_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbe_flag) |-> rsp_err);
endmodule

// File: tb/test_ecc_sram_wrap.sv
module test_ecc_sram_wrap;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scrub_en = 0, wr_notify_en = 0, scrub_notify_en = 0;
  logic req_valid = 0, req_write = 0, req_wide = 0, req_upper = 0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic sbe_clr = 0, dbe_clr = 0;
  logic req_ready, rsp_valid, rsp_err, sbe_wr_pulse, sbe_scrub_pulse, sbe_flag, dbe_flag;
  logic [63:0] rsp_rdata;
  logic [AW-1:0] sbe_addr, dbe_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ecc_sram_wrap #(.ADDR_W(AW)) i_ecc_sram_wrap (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en), .wr_notify_en(wr_notify_en),
    .scrub_notify_en(scrub_notify_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_upper(req_upper),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .sbe_wr_pulse(sbe_wr_pulse),
    .sbe_scrub_pulse(sbe_scrub_pulse), .sbe_flag(sbe_flag), .sbe_addr(sbe_addr),
    .dbe_flag(dbe_flag), .dbe_addr(dbe_addr), .sbe_clr(sbe_clr), .dbe_clr(dbe_clr));

  typedef struct packed {
    logic [1:0]    op;
    logic          up;
    logic [AW-1:0] addr;
    logic [63:0]   d;
    logic [63:0]   exp;
  } vec_t;

  localparam logic [1:0] OP_RD = 2'd0, OP_W64 = 2'd1, OP_W32 = 2'd2;

  localparam vec_t VEC [10] = '{
    '{OP_W64, 1'b0, 4'd3,  64'h1122334455667788, 64'h0},
    '{OP_RD,  1'b0, 4'd3,  64'h0,                64'h1122334455667788},
    '{OP_W32, 1'b0, 4'd3,  64'h99999999AABBCCDD, 64'h0},
    '{OP_RD,  1'b0, 4'd3,  64'h0,                64'h11223344AABBCCDD},
    '{OP_W32, 1'b1, 4'd3,  64'hCAFEF00D12345678, 64'h0},
    '{OP_RD,  1'b0, 4'd3,  64'h0,                64'hCAFEF00DAABBCCDD},
    '{OP_W64, 1'b0, 4'd0,  64'h0,                64'h0},
    '{OP_RD,  1'b0, 4'd0,  64'h0,                64'h0},
    '{OP_W64, 1'b0, 4'd15, 64'hFFFFFFFFFFFFFFFF, 64'h0},
    '{OP_RD,  1'b0, 4'd15, 64'h0,                64'hFFFFFFFFFFFFFFFF}
  };

  logic [63:0] r_d;
  logic r_err, r_pw, r_ps;
  int r_busy;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic up, input logic [AW-1:0] a,
                        input logic [63:0] d);
    bit got;
    int guard;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = (op != OP_RD); req_wide = (op != OP_W32);
    req_upper = up; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    got = 0; r_busy = 0; guard = 0;
    r_d = '0; r_err = 0; r_pw = 0; r_ps = 0;
    forever begin
      if (rsp_valid) begin
        got = 1; r_d = rsp_rdata; r_err = rsp_err; r_pw = sbe_wr_pulse; r_ps = sbe_scrub_pulse;
      end
      if (!req_ready) r_busy++;
      if (got && req_ready) break;
      guard++;
      if (guard > 20) begin
        chk(0, "handshake", 64'(guard), 64'd0);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic flip(input logic [AW-1:0] a, input int b);
    @(negedge clk);
    i_ecc_sram_wrap.mem[a][b] = ~i_ecc_sram_wrap.mem[a][b];
  endtask

  task automatic clear_flags();
    @(negedge clk);
    sbe_clr = 1; dbe_clr = 1;
    @(negedge clk);
    sbe_clr = 0; dbe_clr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !rsp_err && !sbe_wr_pulse && !sbe_scrub_pulse && !sbe_flag && !dbe_flag,
        "R1 reset outputs", {57'd0, req_ready, rsp_valid, rsp_err, sbe_wr_pulse, sbe_scrub_pulse, sbe_flag, dbe_flag},
        64'h40);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 table walk
    for (int i = 0; i < 10; i++) begin
      access(VEC[i].op, VEC[i].up, VEC[i].addr, VEC[i].d);
      if (VEC[i].op == OP_RD) begin
        chk(r_d == VEC[i].exp && !r_err, "R2/R3 table read", r_d, VEC[i].exp);
        chk(r_busy == 1, "R11 read busy", 64'(r_busy), 64'd1);
      end else if (VEC[i].op == OP_W64) begin
        chk(r_busy == 0, "R11 wide write busy", 64'(r_busy), 64'd0);
      end else begin
        chk(r_busy == 2, "R11 partial write busy", 64'(r_busy), 64'd2);
      end
    end

    // R4 R5 correction with scrub off
    access(OP_W64, 0, 4'd5, 64'hDEADBEEF01234567);
    flip(4'd5, 10);
    clear_flags();
    access(OP_RD, 0, 4'd5, 0);
    chk(r_d == 64'hDEADBEEF01234567 && !r_err, "R4 corrected read, scrub off", r_d, 64'hDEADBEEF01234567);
    chk(!r_pw && !r_ps, "R8 no pulse with scrub off", {62'd0, r_pw, r_ps}, 64'd0);
    chk(sbe_flag && sbe_addr == 4'd5, "R10 sbe flag and address", {59'd0, sbe_flag, sbe_addr}, 64'h15);
    clear_flags();
    chk(!sbe_flag, "R10 sbe flag cleared", {63'd0, sbe_flag}, 64'd0);
    access(OP_RD, 0, 4'd5, 0);
    chk(sbe_flag, "R5 fault still stored after plain read", {63'd0, sbe_flag}, 64'd1);

    // R6 R8 scrub on, notify off
    scrub_en = 1;
    clear_flags();
    access(OP_RD, 0, 4'd5, 0);
    chk(r_d == 64'hDEADBEEF01234567 && !r_err, "R4 corrected read, scrub on", r_d, 64'hDEADBEEF01234567);
    chk(r_busy == 2, "R11 scrub read busy", 64'(r_busy), 64'd2);
    chk(!r_ps, "R8 scrub pulse gated off", {63'd0, r_ps}, 64'd0);
    scrub_en = 0;
    clear_flags();
    access(OP_RD, 0, 4'd5, 0);
    chk(!sbe_flag, "R6 scrub removed fault", {63'd0, sbe_flag}, 64'd0);

    // R8 scrub notify on
    flip(4'd5, 20);
    scrub_en = 1; scrub_notify_en = 1;
    access(OP_RD, 0, 4'd5, 0);
    chk(r_ps && !r_pw, "R8 scrub pulse", {62'd0, r_pw, r_ps}, 64'd1);
    access(OP_RD, 0, 4'd5, 0);
    chk(!r_ps, "R8 no pulse on clean word", {63'd0, r_ps}, 64'd0);
    scrub_en = 0; scrub_notify_en = 0;

    // R7 RMW repair of the other lane
    flip(4'd5, 3);
    access(OP_W32, 1, 4'd5, 64'h0BADC0DE00000000);
    chk(!r_pw && !r_err, "R7 write pulse gated off", {62'd0, r_pw, r_err}, 64'd0);
    clear_flags();
    access(OP_RD, 0, 4'd5, 0);
    chk(r_d == 64'h0BADC0DE01234567, "R7 merged word", r_d, 64'h0BADC0DE01234567);
    chk(!sbe_flag, "R7 repaired word stored", {63'd0, sbe_flag}, 64'd0);
    flip(4'd5, 3);
    wr_notify_en = 1;
    access(OP_W32, 0, 4'd5, 64'h0000000076543210);
    chk(r_pw && !r_ps, "R7 write pulse", {62'd0, r_pw, r_ps}, 64'd2);
    access(OP_RD, 0, 4'd5, 0);
    chk(r_d == 64'h0BADC0DE76543210, "R3 lower lane write", r_d, 64'h0BADC0DE76543210);
    wr_notify_en = 0;

    // R9 double errors
    access(OP_W64, 0, 4'd7, 64'h5555AAAA5555AAAA);
    flip(4'd7, 10);
    flip(4'd7, 20);
    clear_flags();
    access(OP_RD, 0, 4'd7, 0);
    chk(r_err, "R9 error with enables off", {63'd0, r_err}, 64'd1);
    chk(dbe_flag && dbe_addr == 4'd7, "R10 dbe flag and address", {59'd0, dbe_flag, dbe_addr}, 64'h17);
    scrub_en = 1; scrub_notify_en = 1; wr_notify_en = 1;
    access(OP_RD, 0, 4'd7, 0);
    chk(r_err && r_busy == 1, "R9 no scrub write-back", {31'd0, r_err, 32'(r_busy)}, 64'h100000001);
    access(OP_W32, 0, 4'd7, 64'h1);
    chk(r_err, "R9 error on partial write", {63'd0, r_err}, 64'd1);
    scrub_en = 0; scrub_notify_en = 0; wr_notify_en = 0;
    access(OP_RD, 0, 4'd7, 0);
    chk(r_err, "R9 word still uncorrectable", {63'd0, r_err}, 64'd1);
    clear_flags();
    chk(!dbe_flag, "R10 dbe flag cleared", {63'd0, dbe_flag}, 64'd0);
    access(OP_W64, 0, 4'd7, 64'h0123456789ABCDEF);
    access(OP_RD, 0, 4'd7, 0);
    chk(!r_err && r_d == 64'h0123456789ABCDEF, "R2 rewrite recovers", r_d, 64'h0123456789ABCDEF);

    finish_run();
  end
endmodule